// File: doc/BRIEF.md
# 16-bit Timer with Prescaler

This block is a sixteen-bit up-counter held as two byte registers that software reads and writes over a small register bus. A control byte chooses the count source and the division ratio. The source is either every clock cycle of the block or rising edges on an external pin. An external pin can pass through a two-flop synchroniser or go straight to the edge detector. A two-bit code sets a prescaler that divides the chosen source by 1, 2, 4 or 8. When the counter wraps from all ones to zero, it sends a one-cycle pulse to the interrupt logic.

The full count value goes out to a neighbouring capture/compare unit, which can return a clear strobe that zeroes the count. A wide-access mode makes sixteen-bit transfers atomic. A read of the low byte freezes a copy of the high byte, and a write of the low byte commits a previously staged high byte at the same edge. The crystal oscillator is not part of the block. Its enable bit is only stored and driven out on a pin.

Top module: `timer16`

## Requirements
- R1: After reset the count is 0x0000, the control byte reads 0x00, `ovf_pulse` is low and `osc_enable` is low.
- R2: The control byte sits at address 0 with the fields: bit 0 run, bit 1 external source, bit 2 bypass synchroniser, bit 3 oscillator enable, bits 5:4 prescale code, bit 6 wide access. Bit 7 always reads 0, and `osc_enable` follows bit 3.
- R3: The count changes only while the run bit is 1, apart from byte writes and the clear strobe. Clearing the run bit freezes the value.
- R4: With the internal source and prescale code c, the count advances once every 2^c clock cycles, measured from the most recent counter byte write.
- R5: The count steps from 0xFFFF to 0x0000 at an edge, and `ovf_pulse` is high for exactly the one cycle that follows that edge.
- R6: In wide mode (bit 6 = 1), reading the low byte (address 1) copies the high byte into a holding register, and reads of address 2 return that copy. In byte mode, address 2 returns the live high byte.
- R7: In wide mode, a write to address 2 only fills the holding register and leaves the count unchanged. A write to address 1 then loads both bytes at the same edge. In byte mode, a write to address 2 changes the high byte at once.
- R8: Any write to address 1 or 2 restarts the prescaler from zero.
- R9: With bits 1 = 1 and 2 = 0, rising edges on `ext_pin` are counted and clock cycles are not. A rising edge appears in the count at the third rising clock edge after the pin goes high.
- R10: With bits 1 = 1 and 2 = 1, a pin rising edge appears in the count at the first rising clock edge after the pin goes high.
- R11: `evt_clear` sets the count to 0x0000 and restarts the prescaler. A counter byte write in the same cycle takes precedence.
- R12: `count_out` equals the high byte joined above the low byte, matching byte-mode reads of addresses 2 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on address 1) |
| bus_addr | input | 2 | 0 control, 1 low byte, 2 high byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| ext_pin | input | 1 | External count input |
| evt_clear | input | 1 | Clear strobe from capture/compare unit |
| count_out | output | 16 | Current count value |
| ovf_pulse | output | 1 | One-cycle overflow indication |
| osc_enable | output | 1 | Stored oscillator enable bit |

## Verification
The bench checks the exact edge at which a synchronised pin edge reaches the count. A design with one stage too many or too few is off by a cycle, and a bypass that still goes through the synchroniser is late by two cycles. It checks the prescaler's phase after a byte write, because a prescaler that is not restarted steps the count early. It covers wide-mode staging, where committing the high byte early would show a torn value on `count_out`, and a missing read copy would return the live high byte. It also covers the wrap pulse and the clear strobe against a simultaneous write; a wrong priority would leave zero where the written byte belongs.

// File: rtl/timer16_pkg.sv
package timer16_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int PS_W   = 2;
    localparam int PC_W   = (1 << PS_W) - 1;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_LOW  = 2'd1,
        A_HIGH = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    // Control byte, bit 6 down to bit 0
    typedef struct packed {
        logic            wide_rw;
        logic [PS_W-1:0] ps_code;
        logic            osc_en;
        logic            no_sync;
        logic            ext_src;
        logic            run;
    } ctrl_t;

    // Per-cycle command to the counter core
    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
        logic rd_lo;
        logic clr;
        logic inc;
    } cnt_cmd_t;

    function automatic logic [PC_W-1:0] ps_limit(input logic [PS_W-1:0] code);
        logic [PC_W-1:0] one;
        one = 1;
        return (one << code) - one;
    endfunction

endpackage

// File: rtl/timer16_clk_src.sv
module timer16_clk_src
    import timer16_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic run,
    input  logic ext_src,
    input  logic no_sync,
    output logic tick
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_s;
    logic                   prev_raw;
    logic                   sync_rise;
    logic                   raw_rise;
    logic                   ext_rise;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_s   <= 1'b0;
            prev_raw <= 1'b0;
        end else begin
            prev_s   <= sync_q[SYNC_STAGES-1];
            prev_raw <= pin;
        end
    end

    assign sync_rise = sync_q[SYNC_STAGES-1] & ~prev_s;
    assign raw_rise  = pin & ~prev_raw;
    assign ext_rise  = no_sync ? raw_rise : sync_rise;
    assign tick      = run & (ext_src ? ext_rise : 1'b1);

endmodule

// File: rtl/timer16_prescale.sv
module timer16_prescale
    import timer16_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            clear,
    input  logic [PS_W-1:0] code,
    output logic            inc
);

    localparam logic [PC_W-1:0] ONE_PC = 1;

    logic [PC_W-1:0] pre_q;
    logic            hit;

    assign hit = (pre_q >= ps_limit(code));
    assign inc = tick & hit;

    always_ff @(posedge clk) begin
        if (rst || clear)  pre_q <= '0;
        else if (tick)     pre_q <= hit ? '0 : pre_q + ONE_PC;
    end

    // R4: a tick below the limit advances the phase by one
    a_r4_phase_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !clear && !hit) |=> (pre_q == $past(pre_q) + ONE_PC));

    // R8: a restart request leaves the phase at zero
    a_r8_phase_restart: assert property (@(posedge clk) disable iff (rst)
        clear |=> (pre_q == '0));

endmodule

// File: rtl/timer16_core.sv
module timer16_core
    import timer16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cnt_cmd_t          cmd,
    input  logic              wide,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output logic [BYTE_W-1:0] hi_view,
    output logic              ovf
);

    localparam logic [CNT_W-1:0] ONE_CNT = 1;

    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;
    logic [BYTE_W-1:0] hbuf_q;

    assign count   = {hi_q, lo_q};
    assign hi_view = wide ? hbuf_q : hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            hi_q   <= '0;
            hbuf_q <= '0;
            ovf    <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (cmd.rd_lo && wide) hbuf_q <= hi_q;
            if (cmd.wr_hi && wide) hbuf_q <= wdata;
            if (cmd.wr_lo) begin
                lo_q <= wdata;
                if (wide) hi_q <= hbuf_q;
            end else if (cmd.wr_hi && !wide) begin
                hi_q <= wdata;
            end else if (cmd.clr) begin
                {hi_q, lo_q} <= '0;
            end else if (cmd.inc) begin
                {hi_q, lo_q} <= count + ONE_CNT;
                ovf          <= &count;
            end
        end
    end

    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (count == '0));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!cmd.inc && !cmd.clr && !cmd.wr_lo && !cmd.wr_hi) |=> $stable(count));

    a_r11_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr && !cmd.wr_lo && !cmd.wr_hi) |=> (count == '0));

    a_r7_stage_only: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr_hi && wide && !cmd.inc && !cmd.clr) |=> $stable(count));

endmodule

// File: rtl/timer16.sv
module timer16
    import timer16_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        ext_pin,
    input  logic        evt_clear,
    output logic [15:0] count_out,
    output logic        ovf_pulse,
    output logic        osc_enable
);

    reg_addr_e         addr_e;
    ctrl_t             ctrl_q;
    cnt_cmd_t          cmd;
    logic              tick;
    logic              inc;
    logic              byte_wr;
    logic [CNT_W-1:0]  count;
    logic [BYTE_W-1:0] hi_view;

    assign addr_e  = reg_addr_e'(bus_addr);
    assign byte_wr = bus_wr && (addr_e == A_LOW || addr_e == A_HIGH);

    always_ff @(posedge clk) begin
        if (rst)                           ctrl_q <= '0;
        else if (bus_wr && addr_e == A_CTRL) ctrl_q <= ctrl_t'(bus_wdata[6:0]);
    end

    timer16_clk_src #(.SYNC_STAGES(2)) i_src (
        .clk     (clk),
        .rst     (rst),
        .pin     (ext_pin),
        .run     (ctrl_q.run),
        .ext_src (ctrl_q.ext_src),
        .no_sync (ctrl_q.no_sync),
        .tick    (tick)
    );

    timer16_prescale i_pre (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .clear (byte_wr | evt_clear),
        .code  (ctrl_q.ps_code),
        .inc   (inc)
    );

    always_comb begin
        cmd.wr_lo = bus_wr && (addr_e == A_LOW);
        cmd.wr_hi = bus_wr && (addr_e == A_HIGH);
        cmd.rd_lo = bus_rd && (addr_e == A_LOW);
        cmd.clr   = evt_clear;
        cmd.inc   = inc;
    end

    timer16_core i_core (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .wide    (ctrl_q.wide_rw),
        .wdata   (bus_wdata),
        .count   (count),
        .hi_view (hi_view),
        .ovf     (ovf_pulse)
    );

    always_comb begin
        case (addr_e)
            A_CTRL:  bus_rdata = {1'b0, ctrl_q};
            A_LOW:   bus_rdata = count[BYTE_W-1:0];
            A_HIGH:  bus_rdata = hi_view;
            default: bus_rdata = '0;
        endcase
    end

    assign count_out  = count;
    assign osc_enable = ctrl_q.osc_en;

    // R3: with run low and no writes or clear, the count holds
    a_r3_run_gate: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !bus_wr && !evt_clear) |=> $stable(count_out));

endmodule

// File: tb/test_timer16.sv
module test_timer16;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd;
    logic [1:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        ext_pin, evt_clear;
    logic [15:0] count_out;
    logic        ovf_pulse, osc_enable;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timer16 i_timer16 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_pin(ext_pin), .evt_clear(evt_clear), .count_out(count_out),
        .ovf_pulse(ovf_pulse), .osc_enable(osc_enable)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 count", count_out, 16'h0000);
        chk("R1 ovf", ovf_pulse, 1'b0);
        chk("R1 osc", osc_enable, 1'b0);
        rd(2'd0, d);
        chk("R1 ctrl", d, 8'h00);
    endtask

    task automatic t_ctrl;
        logic [7:0] d;
        wr(2'd0, 8'hF8);
        rd(2'd0, d);
        chk("R2 ctrl readback bit7 zero", d, 8'h78);
        chk("R2 osc_enable", osc_enable, 1'b1);
        wr(2'd0, 8'h00);
        chk("R2 osc_enable off", osc_enable, 1'b0);
    endtask

    task automatic t_run_gate;
        logic [15:0] v;
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h10);
        wait_n(10);
        chk("R3 disabled holds", count_out, 16'h0010);
        wr(2'd0, 8'h01);
        wait_n(5);
        wr(2'd0, 8'h00);
        v = count_out;
        wait_n(10);
        chk("R3 frozen after stop", count_out, v);
    endtask

    task automatic t_prescale;
        for (int c = 0; c < 4; c++) begin
            wr(2'd0, 8'h01 | 8'(c << 4));
            wr(2'd2, 8'h00);
            wr(2'd1, 8'h00);
            wait_n(24);
            chk($sformatf("R4 prescale code %0d", c), count_out, 16'(24 >> c));
        end
        wr(2'd0, 8'h00);
    endtask

    task automatic t_overflow;
        wr(2'd2, 8'hFF);
        wr(2'd1, 8'hFE);
        wr(2'd0, 8'h01);
        wait_n(1);
        chk("R5 at 0xFFFF", count_out, 16'hFFFF);
        chk("R5 no pulse yet", ovf_pulse, 1'b0);
        wait_n(1);
        chk("R5 wrapped", count_out, 16'h0000);
        chk("R5 pulse", ovf_pulse, 1'b1);
        wait_n(1);
        chk("R5 pulse one cycle", ovf_pulse, 1'b0);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_wide_read;
        logic [7:0] d;
        wr(2'd2, 8'h12);
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'h40);
        rd(2'd1, d);
        chk("R6 low read", d, 8'hFF);
        wr(2'd0, 8'h41);
        wait_n(2);
        chk("R6 count moved on", count_out[15:8], 8'h13);
        rd(2'd2, d);
        chk("R6 high from copy", d, 8'h12);
        wr(2'd0, 8'h00);
        rd(2'd2, d);
        chk("R6 byte mode live high", d, count_out[15:8]);
    endtask

    task automatic t_wide_write;
        logic [15:0] v;
        wr(2'd0, 8'h40);
        v = count_out;
        wr(2'd2, 8'hAB);
        chk("R7 staged high invisible", count_out, v);
        wr(2'd1, 8'hCD);
        chk("R7 atomic load", count_out, 16'hABCD);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h11);
        chk("R7 byte mode high immediate", count_out, 16'h11CD);
    endtask

    task automatic t_pre_restart;
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h31);
        wait_n(5);
        wr(2'd1, 8'h00);
        wait_n(7);
        chk("R8 not yet", count_out, 16'h0000);
        wait_n(1);
        chk("R8 step after full period", count_out, 16'h0001);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_ext_sync;
        wr(2'd0, 8'h03);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);
        wait_n(3);
        chk("R9 no internal counting", count_out, 16'h0000);
        ext_pin = 1'b1;
        wait_n(1);
        chk("R9 edge 1", count_out, 16'h0000);
        wait_n(1);
        chk("R9 edge 2", count_out, 16'h0000);
        wait_n(1);
        chk("R9 edge 3", count_out, 16'h0001);
        wait_n(3);
        for (int i = 0; i < 4; i++) begin
            ext_pin = 1'b0; wait_n(3);
            ext_pin = 1'b1; wait_n(3);
        end
        ext_pin = 1'b0;
        wait_n(4);
        chk("R9 five edges", count_out, 16'h0005);
    endtask

    task automatic t_ext_raw;
        wr(2'd0, 8'h07);
        wait_n(2);
        ext_pin = 1'b1;
        wait_n(1);
        chk("R10 first edge", count_out, 16'h0006);
        ext_pin = 1'b0;
        wait_n(2);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_clear;
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h50);
        wait_n(3);
        chk("R11 before clear", count_out, 16'h0053);
        evt_clear = 1'b1;
        wait_n(1);
        evt_clear = 1'b0;
        chk("R11 cleared", count_out, 16'h0000);
        wait_n(1);
        chk("R11 counts on", count_out, 16'h0001);
        @(negedge clk);
        evt_clear = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h77;
        @(negedge clk);
        evt_clear = 1'b0; bus_wr = 1'b0;
        chk("R11 write wins", count_out[7:0], 8'h77);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_join;
        logic [7:0] lo, hi;
        wr(2'd2, 8'h5A);
        wr(2'd1, 8'hC3);
        rd(2'd1, lo);
        rd(2'd2, hi);
        chk("R12 output joined", count_out, 16'h5AC3);
        chk("R12 reads match", {hi, lo}, count_out);
    endtask

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 2'd0;
        bus_wdata = 8'h00; ext_pin = 1'b0; evt_clear = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl();
        t_run_gate();
        t_prescale();
        t_overflow();
        t_wide_read();
        t_wide_write();
        t_pre_restart();
        t_ext_sync();
        t_ext_raw();
        t_clear();
        t_join();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule